// File: doc/BRIEF.md
# Global Brightness Rescaler

This block moves an entire byte-per-pixel framebuffer to a new global brightness level. When a request arrives with a new level, the block clamps that level so that it is never zero. It forms the signed difference between the clamped level and the level it currently holds, and stores the clamped level as the current one. It then walks the framebuffer once, from address 0 upward. Each pixel is read, and the adjusted value is written back at the same address.

A lit pixel is shifted by the signed difference, and the result is saturated so that it stays lit and never exceeds full scale. A dark pixel is written back as zero. While the walk runs, `busy` is high and any further request is ignored. One cycle after the last write, `done` pulses for a single cycle.

The framebuffer itself sits outside the block, behind a port with a synchronous read. Read data is expected one cycle after `fb_rd_en`.

Top module: `brightness_rescaler`

## Requirements
- R1: A requested level of 0 is treated as 1. Requested levels from 1 to 255 are used unchanged, and the `level` output never reads 0.
- R2: After reset, `level` is 255, and `busy`, `done`, `fb_rd_en` and `fb_wr_en` are all 0.
- R3: A pixel that reads 0 is written back as 0.
- R4: A nonzero pixel is written back as its old value plus (new level − old level), and a result below 1 becomes 1.
- R5: When old value plus difference is above 255, the pixel is written as 255.
- R6: The difference is signed and covers the full span, so a change from 255 to 1 subtracts 254 and a change from 1 to 255 adds 254.
- R7: Each pixel takes a read cycle (`fb_rd_en`=1) followed by a write cycle (`fb_wr_en`=1) at the same address. Addresses run from 0 to PIX_COUNT−1 in ascending order, and `busy` stays high for exactly 2·PIX_COUNT cycles.
- R8: `done` is high for exactly one cycle, and that cycle immediately follows the final write cycle.
- R9: A request raised while `busy` is high has no effect on `level` or on the framebuffer contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe for a new level; sampled only while idle |
| req_level | input | PIX_W | Requested brightness level |
| busy | output | 1 | High while the framebuffer walk is running |
| done | output | 1 | One-cycle pulse after the walk completes |
| level | output | PIX_W | Current stored brightness level |
| fb_addr | output | AW | Framebuffer address |
| fb_rd_en | output | 1 | Framebuffer read strobe |
| fb_rd_data | input | PIX_W | Framebuffer read data, valid one cycle after fb_rd_en |
| fb_wr_en | output | 1 | Framebuffer write strobe |
| fb_wr_data | output | PIX_W | Adjusted pixel value to write |

## Verification
The ignored-request case is the hardest one to reach from the ports. A second request has to land strictly inside a walk, and it has to be lowered again before the `done` cycle, because the block is idle in that cycle and would accept it. The bench starts a walk, raises a conflicting request a few cycles in, holds it for several cycles, and drops it well before the end. It then compares the whole framebuffer and `level` against a model that applied only the first request. Both saturation edges are driven by directed jumps between levels 1 and 255 over images that mix 0, 1, 254 and 255 with random values.

// File: rtl/brs_pkg.sv
package brs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } brs_state_e;
endpackage

// File: rtl/level_clamp.sv
module level_clamp #(
  parameter int PIX_W = 8
) (
  input  logic [PIX_W-1:0]      req_level,
  input  logic [PIX_W-1:0]      cur_level,
  output logic [PIX_W-1:0]      clamped,
  output logic signed [PIX_W:0] offset
);
  always_comb begin
    clamped = (req_level == '0) ? PIX_W'(1) : req_level;
    offset  = $signed({1'b0, clamped}) - $signed({1'b0, cur_level});
  end
endmodule

// File: rtl/pixel_adjust.sv
module pixel_adjust #(
  parameter int PIX_W = 8
) (
  input  logic [PIX_W-1:0]      old_val,
  input  logic signed [PIX_W:0] offset,
  output logic [PIX_W-1:0]      new_val
);
  localparam logic signed [PIX_W+1:0] MAX_S = $signed({2'b00, {PIX_W{1'b1}}});
  localparam logic signed [PIX_W+1:0] ONE_S = $signed({{(PIX_W+1){1'b0}}, 1'b1});

  logic signed [PIX_W+1:0] sum;

  always_comb begin
    sum = $signed({2'b00, old_val}) + $signed({offset[PIX_W], offset});
    if (old_val == '0)      new_val = '0;
    else if (sum < ONE_S)   new_val = PIX_W'(1);
    else if (sum > MAX_S)   new_val = {PIX_W{1'b1}};
    else                    new_val = sum[PIX_W-1:0];
  end
endmodule

// File: rtl/rescale_ctrl.sv
module rescale_ctrl
  import brs_pkg::*;
#(
  parameter int PIX_COUNT = 16,
  parameter int PIX_W     = 8,
  localparam int AW       = (PIX_COUNT > 1) ? $clog2(PIX_COUNT) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic [PIX_W-1:0]      clamped,
  input  logic signed [PIX_W:0] offset_in,
  output logic [PIX_W-1:0]      level,
  output logic signed [PIX_W:0] offset_q,
  output logic                  busy,
  output logic                  done,
  output logic [AW-1:0]         addr,
  output logic                  rd_en,
  output logic                  wr_en
);
  localparam logic [AW-1:0] LAST = AW'(PIX_COUNT - 1);

  brs_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      level    <= {PIX_W{1'b1}};
      offset_q <= '0;
      addr     <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (req_valid) begin
          level    <= clamped;
          offset_q <= offset_in;
          addr     <= '0;
          state    <= ST_RD;
        end
        ST_RD: state <= ST_WR;
        ST_WR: begin
          if (addr == LAST) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            addr  <= addr + AW'(1);
            state <= ST_RD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy  = (state != ST_IDLE);
  assign rd_en = (state == ST_RD);
  assign wr_en = (state == ST_WR);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  level_hold_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(level));

  // R7
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (wr_en && $stable(addr)));

  // R1
  level_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    level != '0);
endmodule

// File: rtl/brightness_rescaler.sv
module brightness_rescaler #(
  parameter int PIX_COUNT = 16,
  parameter int PIX_W     = 8,
  localparam int AW       = (PIX_COUNT > 1) ? $clog2(PIX_COUNT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [PIX_W-1:0] req_level,
  output logic             busy,
  output logic             done,
  output logic [PIX_W-1:0] level,
  output logic [AW-1:0]    fb_addr,
  output logic             fb_rd_en,
  input  logic [PIX_W-1:0] fb_rd_data,
  output logic             fb_wr_en,
  output logic [PIX_W-1:0] fb_wr_data
);
  logic [PIX_W-1:0]      clamped;
  logic signed [PIX_W:0] offset_c;
  logic signed [PIX_W:0] offset_q;

  level_clamp #(.PIX_W(PIX_W)) u_clamp (
    .req_level (req_level),
    .cur_level (level),
    .clamped   (clamped),
    .offset    (offset_c)
  );

  rescale_ctrl #(.PIX_COUNT(PIX_COUNT), .PIX_W(PIX_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .clamped   (clamped),
    .offset_in (offset_c),
    .level     (level),
    .offset_q  (offset_q),
    .busy      (busy),
    .done      (done),
    .addr      (fb_addr),
    .rd_en     (fb_rd_en),
    .wr_en     (fb_wr_en)
  );

  pixel_adjust #(.PIX_W(PIX_W)) u_adj (
    .old_val (fb_rd_data),
    .offset  (offset_q),
    .new_val (fb_wr_data)
  );

  // R3
  dark_stays_dark_chk: assert property (@(posedge clk) disable iff (rst)
    (fb_wr_en && fb_rd_data == '0) |-> (fb_wr_data == '0));

  // R4
  lit_stays_lit_chk: assert property (@(posedge clk) disable iff (rst)
    (fb_wr_en && fb_rd_data != '0) |-> (fb_wr_data != '0));

  // R7
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(fb_rd_en && fb_wr_en));
endmodule

// File: tb/sim_brightness_rescaler.sv
module sim_brightness_rescaler;
  localparam int N  = 16;
  localparam int W  = 8;
  localparam int AW = $clog2(N);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [W-1:0] req_level = '0;
  logic busy, done, fb_rd_en, fb_wr_en;
  logic [W-1:0] level, fb_rd_data, fb_wr_data;
  logic [AW-1:0] fb_addr;

  logic [W-1:0] mem [N];
  logic [W-1:0] exp_img [N];
  int exp_lvl;
  int errors = 0;
  int checks = 0;
  int exp_addr = 0;
  bit mon_on = 1'b0;

  always #5 clk = ~clk;

  brightness_rescaler #(.PIX_COUNT(N), .PIX_W(W)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_level(req_level),
    .busy(busy), .done(done), .level(level), .fb_addr(fb_addr),
    .fb_rd_en(fb_rd_en), .fb_rd_data(fb_rd_data),
    .fb_wr_en(fb_wr_en), .fb_wr_data(fb_wr_data)
  );

  always_ff @(posedge clk) begin
    if (fb_rd_en) fb_rd_data <= mem[fb_addr];
    if (fb_wr_en) mem[fb_addr] <= fb_wr_data;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R7 address order monitor: reads ascend, each write matches the preceding read
  always @(negedge clk) begin
    if (mon_on && fb_rd_en) begin
      check(int'(fb_addr) == exp_addr, "R7 read address", int'(fb_addr), exp_addr);
    end
    if (mon_on && fb_wr_en) begin
      check(int'(fb_addr) == exp_addr, "R7 write address", int'(fb_addr), exp_addr);
      exp_addr++;
    end
  end

  function automatic int clamp_lvl(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int adjust(input int old, input int d);
    int s;
    if (old == 0) return 0;
    s = old + d;
    if (s < 1) return 1;
    if (s > 255) return 255;
    return s;
  endfunction

  task automatic model(input int v);
    int nl = clamp_lvl(v);
    int d  = nl - exp_lvl;
    for (int i = 0; i < N; i++) exp_img[i] = W'(adjust(int'(exp_img[i]), d));
    exp_lvl = nl;
  endtask

  task automatic load_img(input bit rnd);
    for (int i = 0; i < N; i++) begin
      int v;
      case (i % 8)
        0: v = 0;
        1: v = 1;
        2: v = 254;
        3: v = 255;
        default: v = rnd ? int'($urandom_range(0, 255)) : i * 13;
      endcase
      mem[i] = W'(v);
      exp_img[i] = W'(v);
    end
  endtask

  task automatic compare_all(input string req);
    for (int i = 0; i < N; i++)
      check(mem[i] == exp_img[i], req, int'(mem[i]), int'(exp_img[i]));
    check(int'(level) == exp_lvl, "R1 level", int'(level), exp_lvl);
  endtask

  // launch a request; optionally inject a conflicting one mid-walk (R9)
  task automatic run_req(input int v, input bit inject, input int other, input string req);
    int bcnt = 0;
    int it = 0;
    bit got = 1'b0;
    exp_addr = 0;
    mon_on = 1'b1;
    req_level = W'(v);
    req_valid = 1'b1;
    model(v);
    @(negedge clk);
    req_valid = 1'b0;
    while (!got && it < 1000) begin
      it++;
      if (inject && it == 3) begin
        req_level = W'(other);
        req_valid = 1'b1;
      end
      if (inject && it == 8) req_valid = 1'b0;
      if (busy) bcnt++;
      if (done) got = 1'b1;
      else @(negedge clk);
    end
    check(got, "watchdog done seen", int'(got), 1);
    check(bcnt == 2 * N, "R7 busy length", bcnt, 2 * N);
    check(!busy, "R8 busy low at done", int'(busy), 0);
    @(negedge clk);
    check(!done, "R8 done single cycle", int'(done), 0);
    mon_on = 1'b0;
    compare_all(req);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    exp_lvl = 255;
    load_img(1'b0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R2 reset state
    check(int'(level) == 255, "R2 level reset", int'(level), 255);
    check(!busy && !done, "R2 busy/done reset", int'({busy, done}), 0);
    check(!fb_rd_en && !fb_wr_en, "R2 strobes reset", int'({fb_rd_en, fb_wr_en}), 0);

    // R1 R6 R4: 255 -> 0 (clamped to 1), offset -254
    run_req(0, 1'b0, 0, "R4 R6 down to 1");
    // R6 R5: 1 -> 255, offset +254
    load_img(1'b1);
    run_req(255, 1'b0, 0, "R5 R6 up to 255");
    // R4 R3: mid change
    load_img(1'b1);
    run_req(100, 1'b0, 0, "R3 R4 to 100");
    // R5 upward partial
    run_req(200, 1'b0, 0, "R5 to 200");
    // R9 conflicting request mid-walk
    load_img(1'b1);
    run_req(50, 1'b1, 250, "R9 ignored while busy");
    // random requests
    for (int k = 0; k < 10; k++) begin
      if (k % 3 == 0) load_img(1'b1);
      run_req(int'($urandom_range(0, 255)), 1'b0, 0, "R4 random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule